// File: doc/BRIEF.md
# Multi-Output Block FIR Engine

This block computes a long finite impulse response filter over 16-bit signed samples and 16-bit signed coefficients. Both sets of values sit in on-chip memories outside the engine, and the engine reaches them through synchronous read ports. A start strobe carries a base output index `t` and a filter length `M`. One sweep over the memories then yields `R` neighbouring results, `A[t]` to `A[t+R-1]`. Each coefficient and each sample is read once per sweep, so the engine makes about `R` times fewer memory reads than it would by computing one output per sweep.

The engine keeps `R` accumulators and a history of the last `R-1` samples. It takes one coefficient per cycle and multiplies it with the `R` samples it has in view. The sweep is counted in iterations of `S` samples, so `M` must be a whole multiple of `S`. The results leave one after another, lowest index first, on a valid/ready stream as raw 32-bit sums in Q(n+m). The engine accepts no new start until the last result of a pass has been taken.

Top module: `fir_block_engine`

## Requirements
- R1: A pass started with base `t` and length `M` emits exactly `R` results, in the order `A[t]`, `A[t+1]`, ..., `A[t+R-1]`, where `A[u] = sum over i = 0..M-1 of C[i]*X[u-i]`.
- R2: Sample reads form one run of consecutive addresses. The run starts at `t-M+1` and ends at `t+R-1`, and sample addresses wrap modulo 2^SMP_AW.
- R3: The coefficient memory holds the taps in reversed order: address `k` holds `C[M-1-k]`. Coefficient reads start at address 0 and count upward to `M-1`.
- R4: Read data is taken from the memories one cycle after the cycle in which its read enable and address were presented.
- R5: Products are summed into 32-bit signed accumulators that wrap modulo 2^32 and never saturate.
- R6: All accumulators are cleared when a start is accepted, so the results of a pass do not depend on any earlier pass.
- R7: `M` must be a nonzero multiple of `S`, and the sweep is made of `M/S` iterations of `S` samples each.
- R8: `busy` goes high in the cycle after an accepted start. It stays high until the last result of the pass has been accepted. A start that arrives while `busy` is high is ignored.
- R9: `res_valid` is high only while results are being emitted. While `res_valid` is high and `res_ready` is low, `res_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a pass when the engine is idle |
| base_idx | input | SMP_AW | Index `t` of the first output |
| flen | input | LEN_W | Filter length `M` |
| busy | output | 1 | High while a pass is in progress |
| smp_rd | output | 1 | Sample memory read enable |
| smp_addr | output | SMP_AW | Sample memory read address |
| smp_data | input | 16 | Sample read data, one cycle after the read |
| cof_rd | output | 1 | Coefficient memory read enable |
| cof_addr | output | LEN_W | Coefficient memory read address (reversed taps) |
| cof_data | input | 16 | Coefficient read data, one cycle after the read |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result accepted by the consumer |
| res_data | output | 32 | Accumulated result in Q(n+m) |

## Verification
Samples that are zero except for a single unit impulse make the outputs equal to the taps. This shows whether the reversed coefficient order and the per-accumulator sample offset are right, since a swapped or shifted index gives the wrong tap. Random samples and taps over several lengths test the sums themselves. A base index close to zero forces the sample addresses to wrap, and all-minimum operands make the sum overflow 32 bits, which exposes any saturation or sign-extension fault. Back-to-back passes with different data, and a start pulse during a running pass under random backpressure, test the clearing of the accumulators, the rejection of a start while busy, and the holding of results.

// File: rtl/fir_blk_pkg.sv
package fir_blk_pkg;

    localparam int SAMP_W = 16;
    localparam int ACC_W  = 32;

    typedef logic signed [SAMP_W-1:0] samp_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRIME,
        PH_SWEEP,
        PH_TAIL,
        PH_EMIT
    } phase_e;

    // multiply-accumulate in the accumulator width, wrapping on overflow
    function automatic acc_t mac_step(acc_t acc, samp_t smp, samp_t cof);
        acc_t prod;
        prod = acc_t'(smp) * acc_t'(cof);
        return acc + prod;
    endfunction

endpackage

// File: rtl/fir_seq.sv
module fir_seq
    import fir_blk_pkg::*;
#(
    parameter int R      = 4,
    parameter int S      = 3,
    parameter int SMP_AW = 10,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SMP_AW-1:0] base_idx,
    input  logic [LEN_W-1:0]  flen,
    input  logic              emit_done,
    output phase_e            phase,
    output logic              acc_clr,
    output logic              smp_rd,
    output logic [SMP_AW-1:0] smp_addr,
    output logic              cof_rd,
    output logic [LEN_W-1:0]  cof_addr,
    output logic              shift_en,
    output logic              mac_en
);

    localparam int PW = (R > 2) ? $clog2(R - 1) : 1;
    localparam int SW = $clog2(S + 1);
    localparam logic [PW-1:0] PRIME_LAST = PW'(R - 2);
    localparam logic [SW-1:0] SUB_LAST   = SW'(S - 1);

    logic [SMP_AW-1:0] sptr;
    logic [LEN_W-1:0]  kcnt;
    logic [LEN_W-1:0]  len_q;
    logic [PW-1:0]     pcnt;
    logic [SW-1:0]     sub;

    assign acc_clr  = (phase == PH_IDLE) && start;
    assign smp_rd   = (phase == PH_PRIME) || (phase == PH_SWEEP);
    assign cof_rd   = (phase == PH_SWEEP);
    assign smp_addr = sptr;
    assign cof_addr = kcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            sptr     <= '0;
            kcnt     <= '0;
            len_q    <= '0;
            pcnt     <= '0;
            sub      <= '0;
            shift_en <= 1'b0;
            mac_en   <= 1'b0;
        end else begin
            shift_en <= (phase == PH_PRIME);
            mac_en   <= (phase == PH_SWEEP);
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        sptr  <= base_idx - SMP_AW'(flen) + SMP_AW'(1);
                        len_q <= flen;
                        kcnt  <= '0;
                        pcnt  <= '0;
                        sub   <= '0;
                        phase <= PH_PRIME;
                    end
                end
                PH_PRIME: begin
                    sptr <= sptr + SMP_AW'(1);
                    pcnt <= pcnt + PW'(1);
                    if (pcnt == PRIME_LAST) phase <= PH_SWEEP;
                end
                PH_SWEEP: begin
                    sptr <= sptr + SMP_AW'(1);
                    kcnt <= kcnt + LEN_W'(1);
                    sub  <= (sub == SUB_LAST) ? '0 : sub + SW'(1);
                    if (kcnt == len_q - LEN_W'(1)) phase <= PH_TAIL;
                end
                PH_TAIL: phase <= PH_EMIT;
                PH_EMIT: if (emit_done) phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R7: a start must carry a nonzero length that is a multiple of S
    a_r7_len_ok: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && start) |-> (flen != '0 && (flen % S) == 0));

    // R7: the sweep ends at the end of a whole iteration of S samples
    a_r7_whole_blocks: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SWEEP && kcnt == len_q - LEN_W'(1)) |-> (sub == SUB_LAST));

    // R2: during the sweep, sample addresses step by one
    a_r2_smp_step: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SWEEP && $past(smp_rd)) |-> (smp_addr == $past(smp_addr) + SMP_AW'(1)));

    // R3: reversed taps are read from address zero upward
    a_r3_cof_first: assert property (@(posedge clk) disable iff (rst)
        $rose(cof_rd) |-> (cof_addr == '0));

endmodule

// File: rtl/fir_mac_bank.sv
module fir_mac_bank
    import fir_blk_pkg::*;
#(
    parameter int R = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      acc_clr,
    input  logic                      shift_en,
    input  logic                      mac_en,
    input  samp_t                     smp_data,
    input  samp_t                     cof_data,
    output logic [R-1:0][ACC_W-1:0]   acc_o
);

    samp_t hist [R-1];
    samp_t win  [R];

    // window: R-1 older samples from the history, newest from the port
    generate
        for (genvar j = 0; j < R - 1; j++) begin : g_win
            assign win[j] = hist[j];
        end
    endgenerate
    assign win[R-1] = smp_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < R - 1; i++) hist[i] <= '0;
        end else if (shift_en || mac_en) begin
            for (int i = 0; i < R - 2; i++) hist[i] <= hist[i+1];
            hist[R-2] <= smp_data;
        end
    end

    generate
        for (genvar j = 0; j < R; j++) begin : g_acc
            acc_t acc;
            always_ff @(posedge clk) begin
                if (rst || acc_clr) acc <= '0;
                else if (mac_en)    acc <= mac_step(acc, win[j], cof_data);
            end
            assign acc_o[j] = acc;
        end
    endgenerate

    // R6: clearing never coincides with an accumulation step
    a_r6_clr_excl: assert property (@(posedge clk) disable iff (rst)
        acc_clr |-> !mac_en);

    // R4: priming and accumulating data arrive in separate cycles
    a_r4_data_excl: assert property (@(posedge clk) disable iff (rst)
        !(shift_en && mac_en));

endmodule

// File: rtl/fir_emit.sv
module fir_emit
    import fir_blk_pkg::*;
#(
    parameter int R = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    emit_en,
    input  logic [R-1:0][ACC_W-1:0] acc_i,
    input  logic                    res_ready,
    output logic                    res_valid,
    output logic [ACC_W-1:0]        res_data,
    output logic                    emit_done
);

    localparam int IW = (R > 1) ? $clog2(R) : 1;
    localparam logic [IW-1:0] IDX_LAST = IW'(R - 1);

    logic [IW-1:0] idx;

    assign res_valid = emit_en;
    assign res_data  = acc_i[idx];
    assign emit_done = emit_en && res_ready && (idx == IDX_LAST);

    always_ff @(posedge clk) begin
        if (rst)                         idx <= '0;
        else if (emit_en && res_ready)   idx <= (idx == IDX_LAST) ? '0 : idx + IW'(1);
    end

    // R9: a stalled result holds its value
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

    // R1: every pass begins emitting with the lowest index
    a_r1_first_idx: assert property (@(posedge clk) disable iff (rst)
        $rose(res_valid) |-> (idx == '0));

endmodule

// File: rtl/fir_block_engine.sv
module fir_block_engine
    import fir_blk_pkg::*;
#(
    parameter int R      = 4,
    parameter int S      = 3,
    parameter int SMP_AW = 10,
    parameter int LEN_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [SMP_AW-1:0]       base_idx,
    input  logic [LEN_W-1:0]        flen,
    output logic                    busy,
    output logic                    smp_rd,
    output logic [SMP_AW-1:0]       smp_addr,
    input  logic signed [15:0]      smp_data,
    output logic                    cof_rd,
    output logic [LEN_W-1:0]        cof_addr,
    input  logic signed [15:0]      cof_data,
    output logic                    res_valid,
    input  logic                    res_ready,
    output logic signed [31:0]      res_data
);

    phase_e                  phase;
    logic                    acc_clr;
    logic                    shift_en;
    logic                    mac_en;
    logic                    emit_done;
    logic [R-1:0][ACC_W-1:0] accs;

    assign busy = (phase != PH_IDLE);

    fir_seq #(.R(R), .S(S), .SMP_AW(SMP_AW), .LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .base_idx (base_idx),
        .flen     (flen),
        .emit_done(emit_done),
        .phase    (phase),
        .acc_clr  (acc_clr),
        .smp_rd   (smp_rd),
        .smp_addr (smp_addr),
        .cof_rd   (cof_rd),
        .cof_addr (cof_addr),
        .shift_en (shift_en),
        .mac_en   (mac_en)
    );

    fir_mac_bank #(.R(R)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .acc_clr (acc_clr),
        .shift_en(shift_en),
        .mac_en  (mac_en),
        .smp_data(smp_data),
        .cof_data(cof_data),
        .acc_o   (accs)
    );

    fir_emit #(.R(R)) u_emit (
        .clk      (clk),
        .rst      (rst),
        .emit_en  (phase == PH_EMIT),
        .acc_i    (accs),
        .res_ready(res_ready),
        .res_valid(res_valid),
        .res_data (res_data),
        .emit_done(emit_done)
    );

    // R8: busy only drops after the last result handshake
    a_r8_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !emit_done) |=> busy);

endmodule

// File: tb/test_fir_block_engine.sv
module test_fir_block_engine;

    localparam int CLK_P  = 10;
    localparam int R      = 4;
    localparam int S      = 3;
    localparam int SMP_AW = 10;
    localparam int LEN_W  = 8;
    localparam int NSMP   = 1 << SMP_AW;
    localparam int NCOF   = 1 << LEN_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [SMP_AW-1:0] base_idx = '0;
    logic [LEN_W-1:0]  flen = '0;
    logic busy, smp_rd, cof_rd, res_valid;
    logic res_ready = 1'b1;
    logic [SMP_AW-1:0] smp_addr;
    logic [LEN_W-1:0]  cof_addr;
    logic signed [15:0] smp_data, cof_data;
    logic signed [31:0] res_data;

    logic signed [15:0] smem [NSMP];
    logic signed [15:0] cmem [NCOF];

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit bp_rand = 1'b0;
    int exp_q[$];
    string req_q[$];

    always #(CLK_P/2) clk = ~clk;

    // synchronous memories (R4: data one cycle after the read)
    always @(posedge clk) begin
        if (smp_rd) smp_data <= smem[smp_addr];
        if (cof_rd) cof_data <= cmem[cof_addr];
    end

    fir_block_engine #(.R(R), .S(S), .SMP_AW(SMP_AW), .LEN_W(LEN_W)) i_fir_block_engine (
        .clk(clk), .rst(rst), .start(start), .base_idx(base_idx), .flen(flen),
        .busy(busy), .smp_rd(smp_rd), .smp_addr(smp_addr), .smp_data(smp_data),
        .cof_rd(cof_rd), .cof_addr(cof_addr), .cof_data(cof_data),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
    );

    task automatic check(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check(1'b0, "watchdog", cycles, 150000);
            finish_run();
        end
    end

    // per-clock result comparison against the expected stream
    initial begin
        forever begin
            @(negedge clk);
            res_ready = bp_rand ? ($urandom_range(0, 2) != 0) : 1'b1;
            #1;
            if (!rst && res_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 extra result", res_data, 0);
                end else if (res_ready) begin
                    check(res_data == exp_q[0], req_q[0], res_data, exp_q[0]);
                    void'(exp_q.pop_front());
                    void'(req_q.pop_front());
                end
            end
        end
    end

    // reference: direct convolution, taps stored reversed (address k = C[M-1-k])
    function automatic int ref_out(int u, int m);
        int sum = 0;
        for (int i = 0; i < m; i++) begin
            int c = cmem[m - 1 - i];
            int x = smem[(u - i) & (NSMP - 1)];
            sum = sum + c * x;
        end
        return sum;
    endfunction

    task automatic fill_random(int m);
        for (int a = 0; a < NSMP; a++) smem[a] = 16'($urandom);
        for (int a = 0; a < NCOF; a++) cmem[a] = (a < m) ? 16'($urandom) : 16'sd0;
    endtask

    task automatic launch(int t, int m, string req);
        for (int j = 0; j < R; j++) begin
            exp_q.push_back(ref_out(t + j, m));
            req_q.push_back(req);
        end
        @(negedge clk);
        base_idx = SMP_AW'(t);
        flen     = LEN_W'(m);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #2;
        check(busy == 1'b1, "R8 busy after start", busy, 1);
    endtask

    task automatic wait_done(string req);
        int guard = 0;
        while ((busy || exp_q.size() != 0) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        #2;
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        for (int a = 0; a < NSMP; a++) smem[a] = '0;
        for (int a = 0; a < NCOF; a++) cmem[a] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        check(busy == 1'b0, "R8 reset busy", busy, 0);
        check(res_valid == 1'b0, "R9 reset valid", res_valid, 0);

        // R3: unit impulse returns the taps, exposing reversed order
        for (int a = 0; a < NCOF; a++) cmem[a] = (a < 6) ? 16'(a * 37 - 90) : 16'sd0;
        smem[100] = 16'sd1;
        launch(101, 6, "R3 impulse");
        wait_done("R1 impulse count");

        // R1: random data, shortest length
        fill_random(3);
        launch(200, 3, "R1 random M=3");
        wait_done("R1 random M=3 count");

        // R7: longer length under backpressure (R9 hold)
        bp_rand = 1'b1;
        fill_random(48);
        launch(500, 48, "R7 random M=48");
        wait_done("R7 M=48 count");

        // R2: base near zero makes the sample addresses wrap
        fill_random(12);
        launch(2, 12, "R2 address wrap");
        wait_done("R2 wrap count");

        // R5: all-minimum operands overflow 32 bits and must wrap
        for (int a = 0; a < NSMP; a++) smem[a] = -16'sd32768;
        for (int a = 0; a < NCOF; a++) cmem[a] = (a < 12) ? -16'sd32768 : 16'sd0;
        launch(300, 12, "R5 wrap no saturate");
        wait_done("R5 count");

        // R6: back-to-back passes with new data, no carry-over
        fill_random(9);
        launch(700, 9, "R6 pass A");
        wait_done("R6 pass A count");
        for (int a = 0; a < NSMP; a++) smem[a] = 16'($urandom_range(0, 200));
        launch(700, 9, "R6 pass B");
        wait_done("R6 pass B count");

        // R8: a start during a pass is ignored
        fill_random(24);
        launch(400, 24, "R8 ignored start");
        repeat (5) @(negedge clk);
        base_idx = SMP_AW'(50);
        flen     = LEN_W'(3);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R8 ignored start count");
        repeat (10) @(negedge clk);
        check(res_valid == 1'b0, "R8 no extra pass", res_valid, 0);
        check(busy == 1'b0, "R8 idle after pass", busy, 0);

        finish_run();
    end

endmodule